// File: doc/BRIEF.md
# Host Command Transaction Sequencer

This block is a bus master that carries one complete command exchange with a target that holds a command-response buffer behind a small register window. A single `go` pulse starts the exchange. The sequencer first checks that the command fits the target's advertised buffer and that the target is not already reporting an error. It then obtains locality, clears any stale cancel, takes the target through its idle and ready states, and copies the command bytes from a local byte memory into the target's data buffer. After that it rings the start doorbell and polls for completion.

Every polling step has a cycle budget that is reloaded when the step begins. The completion budget comes from the `cmd_timeout` input. That input is sampled when the doorbell write completes, so logic outside the block can derive it from `cmd_code`, the big-endian word the sequencer collects from command bytes 6 to 9 while it copies them. If completion does not arrive in time, the sequencer cancels the command and waits for the doorbell to clear. When recovery succeeds, it carries on with the response. It reads a ten-byte response header, checks the big-endian total length held in header bytes 2 to 5, and copies the remaining body into the local memory at matching offsets. Finally it returns the target to idle and gives locality back. A one-cycle `done` reports an error code and the response length. Each failing step has its own code.

The register window uses byte offsets that the target decodes: locality state 0x00, locality control 0x08, control request 0x40, control status 0x44, cancel 0x48, start 0x4C and command buffer size 0x58. The data buffer is reached through single-byte accesses at `CMD_OFF + i` for the command and at `RSP_OFF + i` for the response. An access is presented on `bus_req`. It completes in the one cycle in which the target raises `bus_ack`, and read data is valid in that same cycle.

Top module: `crb_cmd_sequencer`

## Requirements
- R1: After reset, and whenever reset is applied in the middle of an exchange, `busy`, `done` and `bus_req` are 0 and `err` is 0.
- R2: If `cmd_len` is greater than the 32-bit value read from offset 0x58, the exchange ends with `err` = 1, and no write reaches the target.
- R3: If bit 0 (error) of the status register at 0x44 reads 1 at the start, the exchange ends with `err` = 2, and no write reaches the target.
- R4: The sequencer writes 1 (request, bit 0) to 0x08, then polls 0x00 until bits 7 and 1 both read 1. If the poll budget runs out first, `err` = 3.
- R5: The sequencer writes 0 to 0x48. If status bit 1 (idle) reads 0, it writes 2 (go-idle, bit 1) to 0x40 and polls 0x44 until bit 1 reads 1, with `err` = 4 on budget expiry. If idle already reads 1, no go-idle request is written before the ready request.
- R6: The sequencer writes 1 (go-ready, bit 0) to 0x40, then polls 0x40 until bit 0 reads 0. If the poll budget runs out first, `err` = 5.
- R7: Command bytes 0 to `cmd_len`-1 are written in order as byte accesses to `CMD_OFF + i`, and no byte is written after the doorbell. `cmd_code` holds bytes 6 to 9 with byte 6 as the most significant, and the doorbell write of 1 to 0x4C follows the last byte.
- R8: The sequencer polls 0x4C until it reads 0, within `cmd_timeout` cycles. On expiry it writes 1 to 0x48, polls 0x4C until it reads 0 within `CANCEL_TMO` cycles and then writes 0 to 0x48. If that wait also expires, `err` = 6. After a successful cancel the exchange continues.
- R9: The sequencer reads header bytes 0 to 9 and stores each byte in the local memory at the same offset. The length in bytes 2 to 5 (byte 2 most significant) must lie in the range 10 to `MAX_RSP_LEN`, both included, or the exchange ends with `err` = 7. The body bytes 10 to length-1 are then stored at their own offsets.
- R10: A successful exchange ends by writing 2 to 0x40 and then 2 (relinquish, bit 1) to 0x08. It then reports `done` with `err` = 0 and `rsp_len` equal to the header length.
- R11: While `bus_req` is high and `bus_ack` is low, the address and direction stay unchanged in the next cycle.
- R12: `done` is high for exactly one cycle per exchange, and a `go` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse, accepted when not busy |
| cmd_len | input | LEN_W | Command length in bytes |
| cmd_timeout | input | TMO_W | Completion budget in cycles, sampled at the doorbell |
| busy | output | 1 | An exchange is in progress |
| done | output | 1 | One-cycle end-of-exchange pulse |
| err | output | 4 | 0 ok, 1 too long, 2 device error, 3 locality, 4 idle, 5 ready, 6 cancel, 7 bad length |
| rsp_len | output | LEN_W | Response length of the last successful exchange |
| cmd_code | output | 32 | Big-endian command bytes 6 to 9 |
| bus_req | output | 1 | Access request to the target |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_byte | output | 1 | 1 for a single-byte data-buffer access |
| bus_addr | output | ADDR_W | Byte offset in the target window |
| bus_wdata | output | 32 | Write data (byte accesses use bits 7:0) |
| bus_ack | input | 1 | Access completes in this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| lbuf_addr | output | LEN_W | Local byte memory address |
| lbuf_rdata | input | 8 | Local memory read data (combinational) |
| lbuf_we | output | 1 | Local memory write strobe |
| lbuf_wdata | output | 8 | Local memory write data |

## Verification
The hardest situation to reach is the recovery path: the completion budget has to run out while the target still shows the doorbell set, and the cancel then either clears the doorbell or fails to. The bench's target model can hold the doorbell set indefinitely, and it clears the doorbell on a cancel write only when the vector allows it. Short completion budgets then drive the sequencer into both outcomes. The same model can refuse locality, idle or ready for good, which exercises each poll-budget error, and header lengths of 9, 10, 256 and 257 probe the length bounds.

// File: rtl/crb_cmd_sequencer.sv
module crb_cmd_sequencer #(
  parameter int ADDR_W      = 12,
  parameter int MAX_RSP_LEN = 256,
  parameter int TMO_W       = 16,
  parameter int POLL_TMO    = 256,
  parameter int CANCEL_TMO  = 64,
  parameter int CMD_OFF     = 'h80,
  parameter int RSP_OFF     = 'h80,
  localparam int LEN_W      = $clog2(MAX_RSP_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [TMO_W-1:0]  cmd_timeout,
  output logic              busy,
  output logic              done,
  output logic [3:0]        err,
  output logic [LEN_W-1:0]  rsp_len,
  output logic [31:0]       cmd_code,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic [LEN_W-1:0]  lbuf_addr,
  input  logic [7:0]        lbuf_rdata,
  output logic              lbuf_we,
  output logic [7:0]        lbuf_wdata
);

  localparam logic [ADDR_W-1:0] A_LOCST  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_LOCCTL = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_REQ    = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] A_STS    = ADDR_W'('h44);
  localparam logic [ADDR_W-1:0] A_CANCEL = ADDR_W'('h48);
  localparam logic [ADDR_W-1:0] A_START  = ADDR_W'('h4C);
  localparam logic [ADDR_W-1:0] A_CMDSZ  = ADDR_W'('h58);
  localparam logic [31:0] HDR_LEN  = 32'd10;
  localparam logic [31:0] MAX_LEN  = 32'(MAX_RSP_LEN);
  localparam logic [TMO_W-1:0] T_POLL = TMO_W'(POLL_TMO);
  localparam logic [TMO_W-1:0] T_CAN  = TMO_W'(CANCEL_TMO);

  typedef enum logic [4:0] {
    S_IDLE, S_RDSZ, S_RDSTS, S_LOCREQ, S_LOCPOLL, S_CLRCAN, S_CHKIDLE,
    S_REQIDLE, S_IDLEPOLL, S_REQRDY, S_RDYPOLL, S_CMDWR, S_DOORBELL,
    S_CMPPOLL, S_CANSET, S_CANPOLL, S_CANCLR, S_HDR, S_BODY, S_GOIDLE,
    S_RELQ, S_FINISH
  } st_t;

  st_t              st;
  logic [LEN_W-1:0] idx, len_q, clen_q;
  logic [TMO_W-1:0] tmo;
  logic [31:0]      hlen, code_q;
  logic [3:0]       err_q;
  logic             done_q;

  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign err        = err_q;
  assign rsp_len    = len_q;
  assign cmd_code   = code_q;
  assign bus_req    = (st != S_IDLE) && (st != S_FINISH);
  assign lbuf_addr  = idx;
  assign lbuf_we    = ((st == S_HDR) || (st == S_BODY)) && bus_ack;
  assign lbuf_wdata = bus_rdata[7:0];

  wire tmo_out = (tmo == '0);

  always_comb begin
    bus_we    = 1'b0;
    bus_byte  = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      S_RDSZ:                         bus_addr = A_CMDSZ;
      S_RDSTS, S_CHKIDLE, S_IDLEPOLL: bus_addr = A_STS;
      S_LOCPOLL:                      bus_addr = A_LOCST;
      S_RDYPOLL:                      bus_addr = A_REQ;
      S_CMPPOLL, S_CANPOLL:           bus_addr = A_START;
      S_LOCREQ: begin bus_we = 1'b1; bus_addr = A_LOCCTL; bus_wdata = 32'd1; end
      S_RELQ:   begin bus_we = 1'b1; bus_addr = A_LOCCTL; bus_wdata = 32'd2; end
      S_CLRCAN, S_CANCLR: begin bus_we = 1'b1; bus_addr = A_CANCEL; end
      S_CANSET: begin bus_we = 1'b1; bus_addr = A_CANCEL; bus_wdata = 32'd1; end
      S_REQIDLE, S_GOIDLE: begin bus_we = 1'b1; bus_addr = A_REQ; bus_wdata = 32'd2; end
      S_REQRDY: begin bus_we = 1'b1; bus_addr = A_REQ; bus_wdata = 32'd1; end
      S_DOORBELL: begin bus_we = 1'b1; bus_addr = A_START; bus_wdata = 32'd1; end
      S_CMDWR: begin
        bus_we    = 1'b1;
        bus_byte  = 1'b1;
        bus_addr  = ADDR_W'(CMD_OFF) + ADDR_W'(idx);
        bus_wdata = {24'd0, lbuf_rdata};
      end
      S_HDR, S_BODY: begin
        bus_byte = 1'b1;
        bus_addr = ADDR_W'(RSP_OFF) + ADDR_W'(idx);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      len_q  <= '0;
      clen_q <= '0;
      tmo    <= '0;
      hlen   <= '0;
      code_q <= '0;
      err_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!tmo_out) tmo <= tmo - TMO_W'(1);
      case (st)
        S_IDLE: if (go) begin
          st     <= S_RDSZ;
          clen_q <= cmd_len;
          err_q  <= '0;
          len_q  <= '0;
          code_q <= '0;
          hlen   <= '0;
          idx    <= '0;
        end
        S_RDSZ: if (bus_ack) begin
          if (32'(clen_q) > bus_rdata) begin err_q <= 4'd1; st <= S_FINISH; end
          else st <= S_RDSTS;
        end
        S_RDSTS: if (bus_ack) begin
          if (bus_rdata[0]) begin err_q <= 4'd2; st <= S_FINISH; end
          else st <= S_LOCREQ;
        end
        S_LOCREQ: if (bus_ack) begin tmo <= T_POLL; st <= S_LOCPOLL; end
        S_LOCPOLL: if (bus_ack) begin
          if (bus_rdata[7] && bus_rdata[1]) st <= S_CLRCAN;
          else if (tmo_out) begin err_q <= 4'd3; st <= S_FINISH; end
        end
        S_CLRCAN: if (bus_ack) st <= S_CHKIDLE;
        S_CHKIDLE: if (bus_ack) st <= bus_rdata[1] ? S_REQRDY : S_REQIDLE;
        S_REQIDLE: if (bus_ack) begin tmo <= T_POLL; st <= S_IDLEPOLL; end
        S_IDLEPOLL: if (bus_ack) begin
          if (bus_rdata[1]) st <= S_REQRDY;
          else if (tmo_out) begin err_q <= 4'd4; st <= S_FINISH; end
        end
        S_REQRDY: if (bus_ack) begin tmo <= T_POLL; st <= S_RDYPOLL; end
        S_RDYPOLL: if (bus_ack) begin
          if (!bus_rdata[0]) begin
            idx <= '0;
            st  <= (clen_q == '0) ? S_DOORBELL : S_CMDWR;
          end else if (tmo_out) begin err_q <= 4'd5; st <= S_FINISH; end
        end
        S_CMDWR: if (bus_ack) begin
          if (idx >= LEN_W'(6) && idx <= LEN_W'(9)) code_q <= {code_q[23:0], lbuf_rdata};
          if (idx == clen_q - LEN_W'(1)) st <= S_DOORBELL;
          else idx <= idx + LEN_W'(1);
        end
        S_DOORBELL: if (bus_ack) begin tmo <= cmd_timeout; st <= S_CMPPOLL; end
        S_CMPPOLL: if (bus_ack) begin
          if (bus_rdata == 32'd0) begin idx <= '0; st <= S_HDR; end
          else if (tmo_out) st <= S_CANSET;
        end
        S_CANSET: if (bus_ack) begin tmo <= T_CAN; st <= S_CANPOLL; end
        S_CANPOLL: if (bus_ack) begin
          if (bus_rdata == 32'd0) st <= S_CANCLR;
          else if (tmo_out) begin err_q <= 4'd6; st <= S_FINISH; end
        end
        S_CANCLR: if (bus_ack) begin idx <= '0; st <= S_HDR; end
        S_HDR: if (bus_ack) begin
          if (idx >= LEN_W'(2) && idx <= LEN_W'(5)) hlen <= {hlen[23:0], bus_rdata[7:0]};
          if (idx == LEN_W'(9)) begin
            if (hlen < HDR_LEN || hlen > MAX_LEN) begin
              err_q <= 4'd7;
              st    <= S_FINISH;
            end else begin
              len_q <= hlen[LEN_W-1:0];
              idx   <= LEN_W'(10);
              st    <= (hlen == HDR_LEN) ? S_GOIDLE : S_BODY;
            end
          end else idx <= idx + LEN_W'(1);
        end
        S_BODY: if (bus_ack) begin
          if (idx == len_q - LEN_W'(1)) st <= S_GOIDLE;
          else idx <= idx + LEN_W'(1);
        end
        S_GOIDLE: if (bus_ack) st <= S_RELQ;
        S_RELQ:   if (bus_ack) st <= S_FINISH;
        S_FINISH: begin done_q <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/crb_seq_checker.sv
module crb_seq_checker #(
  parameter int ADDR_W      = 12,
  parameter int LEN_W       = 9,
  parameter int MAX_RSP_LEN = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              go,
  input logic              busy,
  input logic              done,
  input logic [3:0]        err,
  input logic [LEN_W-1:0]  rsp_len,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              lbuf_we
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go && !done) |=> !done || busy); // R12

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R11

  AST_LBUF_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    lbuf_we |-> bus_ack && !bus_we); // R9

  AST_OK_LEN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == 4'd0) |-> (rsp_len >= LEN_W'(10)) && (32'(rsp_len) <= 32'(MAX_RSP_LEN))); // R10

  AST_ERR_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> err <= 4'd7); // R8

endmodule

bind crb_cmd_sequencer crb_seq_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_RSP_LEN(MAX_RSP_LEN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done), .err(err),
  .rsp_len(rsp_len), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_ack(bus_ack), .lbuf_we(lbuf_we)
);

// File: tb/crb_cmd_sequencer_tb_top.sv
module crb_cmd_sequencer_tb_top;
  localparam int LEN_W = 9;

  typedef struct packed {
    logic [15:0] clen;
    logic [31:0] adv;
    logic        sts_err;
    logic        loc_ok;
    logic        idle_init;
    logic        idle_ok;
    logic        rdy_ok;
    logic [7:0]  start_busy;
    logic [15:0] tmo;
    logic        cancel_ok;
    logic [31:0] rlen;
    logic [3:0]  exp_err;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'd16, 32'd64, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd3,   16'd100, 1'b1, 32'd20,  4'd0},
    '{16'd12, 32'd64, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd1,   16'd100, 1'b1, 32'd10,  4'd0},
    '{16'd20, 32'd64, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd2,   16'd100, 1'b1, 32'd256, 4'd0},
    '{16'd16, 32'd64, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd2,   16'd100, 1'b1, 32'd9,   4'd7},
    '{16'd16, 32'd64, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd2,   16'd100, 1'b1, 32'd257, 4'd7},
    '{16'd65, 32'd64, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd2,   16'd100, 1'b1, 32'd20,  4'd1},
    '{16'd64, 32'd64, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'd4,   16'd100, 1'b1, 32'd30,  4'd0},
    '{16'd16, 32'd64, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd2,   16'd100, 1'b1, 32'd20,  4'd2},
    '{16'd16, 32'd64, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd2,   16'd100, 1'b1, 32'd20,  4'd3},
    '{16'd16, 32'd64, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd2,   16'd100, 1'b1, 32'd20,  4'd4},
    '{16'd16, 32'd64, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'd2,   16'd100, 1'b1, 32'd20,  4'd5},
    '{16'd16, 32'd64, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd255, 16'd20,  1'b1, 32'd14,  4'd0},
    '{16'd16, 32'd64, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd255, 16'd20,  1'b0, 32'd14,  4'd6}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [15:0] cmd_timeout = '0;
  logic busy, done, bus_req, bus_we, bus_byte, lbuf_we;
  logic [3:0] err;
  logic [LEN_W-1:0] rsp_len, lbuf_addr;
  logic [31:0] cmd_code, bus_wdata;
  logic [11:0] bus_addr;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic [7:0] lbuf_rdata, lbuf_wdata;
  logic [7:0] lmem [0:511];
  logic [7:0] devbuf [0:511];

  always #5 clk = ~clk;

  crb_cmd_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd_len(cmd_len), .cmd_timeout(cmd_timeout),
    .busy(busy), .done(done), .err(err), .rsp_len(rsp_len), .cmd_code(cmd_code),
    .bus_req(bus_req), .bus_we(bus_we), .bus_byte(bus_byte), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .lbuf_addr(lbuf_addr), .lbuf_rdata(lbuf_rdata), .lbuf_we(lbuf_we),
    .lbuf_wdata(lbuf_wdata)
  );

  assign lbuf_rdata = lmem[lbuf_addr];
  always @(posedge clk) if (lbuf_we) lmem[lbuf_addr] <= lbuf_wdata;

  vec_t m;
  int total = 0, bad = 0, cycles = 0, done_cnt = 0;
  int wcnt, idle_req_n, can_n, byte_after_start, loc_reads, rdy_reads, start_left;
  bit loc_req, rdy_pend, rdy_seen, idle_f, start_rung;
  int prev_wa, prev_wd, last_wa, last_wd;

  function automatic logic [7:0] cpat(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] rbyte(int i, logic [31:0] len);
    case (i)
      2: return len[31:24];
      3: return len[23:16];
      4: return len[15:8];
      5: return len[7:0];
      default: return 8'((i * 5 + 17) & 255);
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (done) done_cnt++;
    if (!rst_n) bus_ack <= 1'b0;
    else if (bus_req && !bus_ack) begin
      int a;
      logic [31:0] rd;
      a = int'(bus_addr);
      rd = '0;
      bus_ack <= 1'b1;
      if (bus_we) begin
        wcnt++;
        prev_wa = last_wa; prev_wd = last_wd;
        last_wa = a; last_wd = int'(bus_wdata);
        if (bus_byte) begin
          if (a >= 128) devbuf[a-128] = bus_wdata[7:0];
          if (start_rung) byte_after_start++;
        end else case (a)
          'h08: if (bus_wdata[0]) begin loc_req = 1; loc_reads = 0; end
          'h40: begin
            if (bus_wdata[1]) begin
              if (!rdy_seen) idle_req_n++;
              if (m.idle_ok) idle_f = 1;
            end
            if (bus_wdata[0]) begin rdy_seen = 1; rdy_pend = 1; rdy_reads = 0; end
          end
          'h48: if (bus_wdata[0]) begin can_n++; if (m.cancel_ok) start_left = 0; end
          'h4C: if (bus_wdata[0]) begin start_rung = 1; start_left = int'(m.start_busy); end
          default: ;
        endcase
      end else begin
        if (bus_byte) rd = {24'd0, rbyte(a - 128, m.rlen)};
        else case (a)
          'h00: begin
            if (loc_req && m.loc_ok && loc_reads >= 2) rd = 32'h82;
            loc_reads++;
          end
          'h40: begin
            if (rdy_pend && m.rdy_ok && rdy_reads >= 2) rdy_pend = 0;
            rdy_reads++;
            rd = {31'd0, rdy_pend};
          end
          'h44: rd = {30'd0, idle_f, m.sts_err};
          'h4C: begin
            if (start_left == 255) rd = 32'd1;
            else if (start_left > 0) begin rd = 32'd1; start_left--; end
          end
          'h58: rd = m.adv;
          default: ;
        endcase
      end
      bus_rdata <= rd;
    end else bus_ack <= 1'b0;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic string etag(logic [3:0] e);
    case (e)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R8";
      4'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic start_run(vec_t v);
    m = v;
    wcnt = 0; idle_req_n = 0; can_n = 0; byte_after_start = 0;
    loc_reads = 0; rdy_reads = 0; start_left = 0;
    loc_req = 0; rdy_pend = 0; rdy_seen = 0; start_rung = 0;
    idle_f = v.idle_init;
    prev_wa = -1; prev_wd = -1; last_wa = -1; last_wd = -1;
    for (int i = 0; i < 512; i++) begin lmem[i] = cpat(i); devbuf[i] = 8'h00; end
    cmd_len = LEN_W'(v.clen);
    cmd_timeout = v.tmo;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  initial begin
    bit got;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_req && err == 4'd0, "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      int mism;
      v = VECS[k];
      start_run(v);
      wait_done(got);
      chk(got, "R12 done seen", int'(got), 1);
      chk(err == v.exp_err, etag(v.exp_err), int'(err), int'(v.exp_err));
      if (v.exp_err == 4'd1 || v.exp_err == 4'd2)
        chk(wcnt == 0, etag(v.exp_err), wcnt, 0);
      if (v.exp_err == 4'd0) begin
        chk(32'(rsp_len) == v.rlen, "R10 rsp_len", int'(rsp_len), int'(v.rlen));
        chk(prev_wa == 'h40 && prev_wd == 2, "R10 go-idle before release", prev_wa, 'h40);
        chk(last_wa == 'h08 && last_wd == 2, "R10 relinquish last", last_wa, 'h08);
        chk(idle_req_n == (v.idle_init ? 0 : 1), "R5 idle request count", idle_req_n,
            v.idle_init ? 0 : 1);
        chk(can_n == ((v.start_busy == 8'd255) ? 1 : 0), "R8 cancel count", can_n,
            (v.start_busy == 8'd255) ? 1 : 0);
        chk(cmd_code == {cpat(6), cpat(7), cpat(8), cpat(9)}, "R7 cmd_code",
            int'(cmd_code), int'({cpat(6), cpat(7), cpat(8), cpat(9)}));
        chk(byte_after_start == 0, "R7 no byte after doorbell", byte_after_start, 0);
        mism = 0;
        for (int i = 0; i < int'(v.clen); i++) if (devbuf[i] != cpat(i)) mism++;
        chk(mism == 0, "R7 command bytes", mism, 0);
        mism = 0;
        for (int i = 0; i < int'(v.rlen); i++) if (lmem[i] != rbyte(i, v.rlen)) mism++;
        chk(mism == 0, "R9 response bytes", mism, 0);
      end
      if (v.exp_err == 4'd6) chk(can_n == 1, "R8 cancel issued", can_n, 1);
      @(negedge clk);
    end

    begin
      int d0;
      d0 = done_cnt;
      start_run(VECS[0]);
      repeat (30) @(negedge clk);
      go = 1'b1;
      @(negedge clk) go = 1'b0;
      wait_done(got);
      repeat (100) @(negedge clk);
      chk(done_cnt - d0 == 1, "R12 go while busy ignored", done_cnt - d0, 1);
      chk(!busy, "R12 idle after run", int'(busy), 0);
    end

    start_run(VECS[0]);
    repeat (25) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!busy && !bus_req && !done && err == 4'd0, "R1 mid-run reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=0", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule